// File: doc/BRIEF.md
# Multi-Entry Timer Table Scanner

This block keeps a table of sixteen independent countdown timers. Each entry has a valid flag, a restart flag, a reload value and a running count. Each accepted tick starts one pass over the whole table, one entry per step. A valid entry's running count drops by one in its step. When an entry runs out, its event bit is latched. The entry is then either reloaded from its reload value or retired.

Software programs entries through a single 32-bit command word. A command changes the table at once, but a count only moves during the scan that follows a later tick. A small register port gives access to three registers:
- the event register, which is write-one-to-clear;
- the per-timer interrupt mask;
- a tick counter that advances once per completed scan.

A single interrupt line is the OR of the masked events. A priority input from the surrounding system can hold the scanner between entries for as long as it stays high. Ticks that arrive during a scan are queued and serviced afterwards.

Top module: `tmr_table_scan`

## Requirements
- R1: After reset, the event, mask and tick-count outputs are zero, `irq_o` and `busy_o` are low, and every table entry is invalid.
- R2: A command on `cmd_valid_i` decodes `cmd_word_i` as follows: bit 31 is enable, bit 30 is auto-restart, bits 19:16 are the entry index and bits 15:0 are the count. The command loads both the reload value and the running count of that entry, and writes enable into the entry's valid flag. No count changes until a tick is accepted.
- R3: Each accepted tick causes exactly one scan of all 16 entries, in index order, and each valid entry is decremented once per scan. An entry loaded with count N times out in the scan of the N-th tick after the command. A count of 0 behaves like a count of 1.
- R4: A timeout of entry i sets bit i of the event register. A register write to address 0 clears the event bits where the write data has ones. If a clear and a set of the same bit fall in the same cycle, the set wins.
- R5: On timeout with auto-restart, the entry stays valid and its running count is reloaded, so it times out again every N ticks. Without auto-restart, the entry becomes invalid and raises no further events.
- R6: While `hipri_req_i` or `cmd_valid_i` is high, the scanner processes no entry and stays on its current index. It resumes from that index afterwards. A command therefore always wins over a scan step for the same entry.
- R7: The tick counter at address 2 increments by one when each scan completes. A register write to address 2 loads the written value (writing 0 restarts the measurement), and such a write wins over an increment in the same cycle.
- R8: The mask register sits at address 1. `irq_o` is registered: it is high in the cycle after any bit is set in both the event register and the mask register.
- R9: While `run_en_i` is low, `tick_i` is ignored: no scan starts and the tick counter does not change.
- R10: Ticks accepted while a scan is running are queued, up to 2^PEND_W-1 of them. They are serviced by back-to-back scans, each one completing and counting separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en_i | input | 1 | Master enable for accepting ticks |
| tick_i | input | 1 | Periodic tick, one cycle per tick |
| hipri_req_i | input | 1 | Higher-priority request; stalls the scan between entries |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_word_i | input | 32 | Command word (enable, restart, index, count) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 event, 1 mask, 2 tick count |
| reg_wdata_i | input | 32 | Register write data |
| event_o | output | NUM_TMR | Latched timeout events |
| mask_o | output | NUM_TMR | Interrupt mask |
| tick_cnt_o | output | CNT_W | Completed-scan counter |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Scan running or ticks pending |

## Verification
The assertions check the following on every cycle:
- the interrupt line follows the masked events one cycle late;
- event bits never drop except through a clear write;
- the tick counter moves by at most one unless it is written;
- a stall holds the scan index, and an unstalled step advances it by exactly one;
- a scan ends right after its last entry;
- ticks are ignored while the master enable is low.

Only the bench's scenarios can show the following:
- the exact tick on which an entry times out;
- that a restarting entry fires again after its full period;
- that a retired entry stays silent;
- that a command issued during a stall replaces an entry's count;
- that queued ticks each produce a full scan.

// File: rtl/tmr_scan_pkg.sv
package tmr_scan_pkg;
  // command word field positions (fixed software encoding)
  localparam int CMD_EN_BIT  = 31;
  localparam int CMD_RST_BIT = 30;
  localparam int CMD_IDX_LSB = 16;
  localparam int CMD_CNT_LSB = 0;

  typedef enum logic [1:0] {
    RA_EVENT = 2'd0,
    RA_MASK  = 2'd1,
    RA_TICKS = 2'd2
  } reg_addr_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/tmr_table.sv
module tmr_table #(
  parameter int NUM_TMR = 16,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(NUM_TMR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic             cmd_en,
  input  logic             cmd_rst,
  input  logic [CNT_W-1:0] cmd_cnt,
  input  logic             upd_we,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [CNT_W-1:0] upd_cnt,
  input  logic             upd_retire,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_restart,
  output logic [CNT_W-1:0] rd_init,
  output logic [CNT_W-1:0] rd_cur
);
  logic [CNT_W-1:0] init_mem [NUM_TMR];
  logic [CNT_W-1:0] cur_mem  [NUM_TMR];
  logic [NUM_TMR-1:0] valid_q;
  logic [NUM_TMR-1:0] restart_q;

  // single write port per array; a command takes precedence
  always_ff @(posedge clk) begin
    if (cmd_we) begin
      init_mem[cmd_idx] <= cmd_cnt;
      cur_mem[cmd_idx]  <= cmd_cnt;
    end else if (upd_we) begin
      cur_mem[upd_idx] <= upd_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= '0;
      restart_q <= '0;
    end else if (cmd_we) begin
      valid_q[cmd_idx]   <= cmd_en;
      restart_q[cmd_idx] <= cmd_rst;
    end else if (upd_we && upd_retire) begin
      valid_q[upd_idx] <= 1'b0;
    end
  end

  assign rd_valid   = valid_q[rd_idx];
  assign rd_restart = restart_q[rd_idx];
  assign rd_init    = init_mem[rd_idx];
  assign rd_cur     = cur_mem[rd_idx];
endmodule

// File: rtl/tmr_scan_ctrl.sv
module tmr_scan_ctrl
  import tmr_scan_pkg::*;
#(
  parameter int NUM_TMR = 16,
  parameter int CNT_W   = 16,
  parameter int PEND_W  = 3,
  localparam int IDX_W  = $clog2(NUM_TMR),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TMR - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_en_i,
  input  logic             hold_i,
  input  logic             rd_valid,
  input  logic             rd_restart,
  input  logic [CNT_W-1:0] rd_init,
  input  logic [CNT_W-1:0] rd_cur,
  output logic [IDX_W-1:0] idx_o,
  output logic             active_o,
  output logic             upd_we,
  output logic [CNT_W-1:0] upd_cnt,
  output logic             upd_retire,
  output logic             evt_we,
  output logic             done_o,
  output logic             busy_o
);
  scan_state_e state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PEND_W-1:0] pend_q, pend_n;
  logic start, step, expire;

  assign start  = (state_q == S_IDLE) && (pend_q != '0);
  assign step   = (state_q == S_SCAN) && !hold_i;
  assign expire = (rd_cur <= CNT_W'(1));

  always_comb begin
    pend_n = pend_q;
    if (start) pend_n = pend_n - 1'b1;
    if (tick_i && run_en_i && (pend_n != '1)) pend_n = pend_n + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      pend_q  <= '0;
    end else begin
      pend_q <= pend_n;
      if (start) begin
        state_q <= S_SCAN;
        idx_q   <= '0;
      end else if (step) begin
        if (idx_q == LAST_IDX) state_q <= S_IDLE;
        else                   idx_q   <= idx_q + 1'b1;
      end
    end
  end

  assign upd_we     = step && rd_valid;
  assign upd_retire = expire && !rd_restart;
  assign upd_cnt    = !expire ? (rd_cur - 1'b1) : (rd_restart ? rd_init : '0);
  assign evt_we     = step && rd_valid && expire;
  assign done_o     = step && (idx_q == LAST_IDX);
  assign idx_o      = idx_q;
  assign active_o   = (state_q == S_SCAN);
  assign busy_o     = (state_q == S_SCAN) || (pend_q != '0);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_scan_pkg::*;
#(
  parameter int NUM_TMR = 16,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(NUM_TMR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  input  logic               evt_we,
  input  logic [IDX_W-1:0]   evt_idx,
  input  logic               done_i,
  output logic [NUM_TMR-1:0] event_o,
  output logic [NUM_TMR-1:0] mask_o,
  output logic [CNT_W-1:0]   tick_cnt_o,
  output logic               irq_o
);
  logic [NUM_TMR-1:0] clr_bits, set_bits;
  logic wr_ev, wr_mk, wr_tc;

  assign wr_ev = reg_wr_i && (reg_addr_i == RA_EVENT);
  assign wr_mk = reg_wr_i && (reg_addr_i == RA_MASK);
  assign wr_tc = reg_wr_i && (reg_addr_i == RA_TICKS);
  assign clr_bits = wr_ev ? reg_wdata_i[NUM_TMR-1:0] : '0;
  assign set_bits = evt_we ? (NUM_TMR'(1) << evt_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      event_o    <= '0;
      mask_o     <= '0;
      tick_cnt_o <= '0;
      irq_o      <= 1'b0;
    end else begin
      event_o <= (event_o & ~clr_bits) | set_bits;
      if (wr_mk) mask_o <= reg_wdata_i[NUM_TMR-1:0];
      if (wr_tc)       tick_cnt_o <= reg_wdata_i[CNT_W-1:0];
      else if (done_i) tick_cnt_o <= tick_cnt_o + 1'b1;
      irq_o <= |(event_o & mask_o);
    end
  end
endmodule

// File: rtl/tmr_table_scan.sv
module tmr_table_scan
  import tmr_scan_pkg::*;
#(
  parameter int NUM_TMR = 16,
  parameter int CNT_W   = 16,
  parameter int PEND_W  = 3,
  localparam int IDX_W  = $clog2(NUM_TMR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en_i,
  input  logic               tick_i,
  input  logic               hipri_req_i,
  input  logic               cmd_valid_i,
  input  logic [31:0]        cmd_word_i,
  input  logic               reg_wr_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [NUM_TMR-1:0] event_o,
  output logic [NUM_TMR-1:0] mask_o,
  output logic [CNT_W-1:0]   tick_cnt_o,
  output logic               irq_o,
  output logic               busy_o
);
  logic [IDX_W-1:0] scan_idx;
  logic             scan_active;
  logic             rd_valid, rd_restart;
  logic [CNT_W-1:0] rd_init, rd_cur, upd_cnt;
  logic             upd_we, upd_retire, evt_we, scan_done;
  logic             unused_cmd_bits;

  assign unused_cmd_bits = ^{cmd_word_i[29:CMD_IDX_LSB+IDX_W], cmd_word_i[CMD_IDX_LSB-1:CNT_W]};

  tmr_table #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) table_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_we     (cmd_valid_i),
    .cmd_idx    (cmd_word_i[CMD_IDX_LSB +: IDX_W]),
    .cmd_en     (cmd_word_i[CMD_EN_BIT]),
    .cmd_rst    (cmd_word_i[CMD_RST_BIT]),
    .cmd_cnt    (cmd_word_i[CMD_CNT_LSB +: CNT_W]),
    .upd_we     (upd_we),
    .upd_idx    (scan_idx),
    .upd_cnt    (upd_cnt),
    .upd_retire (upd_retire),
    .rd_idx     (scan_idx),
    .rd_valid   (rd_valid),
    .rd_restart (rd_restart),
    .rd_init    (rd_init),
    .rd_cur     (rd_cur)
  );

  tmr_scan_ctrl #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W), .PEND_W(PEND_W)) scan_i (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .run_en_i   (run_en_i),
    .hold_i     (hipri_req_i || cmd_valid_i),
    .rd_valid   (rd_valid),
    .rd_restart (rd_restart),
    .rd_init    (rd_init),
    .rd_cur     (rd_cur),
    .idx_o      (scan_idx),
    .active_o   (scan_active),
    .upd_we     (upd_we),
    .upd_cnt    (upd_cnt),
    .upd_retire (upd_retire),
    .evt_we     (evt_we),
    .done_o     (scan_done),
    .busy_o     (busy_o)
  );

  tmr_regs #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) regs_i (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .evt_we      (evt_we),
    .evt_idx     (scan_idx),
    .done_i      (scan_done),
    .event_o     (event_o),
    .mask_o      (mask_o),
    .tick_cnt_o  (tick_cnt_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/tmr_table_scan_chk.sv
module tmr_table_scan_chk #(
  parameter int NUM_TMR = 16,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(NUM_TMR),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TMR - 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               run_en_i,
  input logic               hipri_req_i,
  input logic               cmd_valid_i,
  input logic               reg_wr_i,
  input logic [1:0]         reg_addr_i,
  input logic [NUM_TMR-1:0] event_o,
  input logic [NUM_TMR-1:0] mask_o,
  input logic [CNT_W-1:0]   tick_cnt_o,
  input logic               irq_o,
  input logic               busy_o,
  input logic               scan_active,
  input logic [IDX_W-1:0]   scan_idx
);
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |($past(event_o) & $past(mask_o)))); // R8

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_i && reg_addr_i == 2'd0) |=> ((event_o & $past(event_o)) == $past(event_o))); // R4

  AST_TICKCNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_i && reg_addr_i == 2'd2) |=>
      (tick_cnt_o == $past(tick_cnt_o) || tick_cnt_o == $past(tick_cnt_o) + 1'b1)); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (scan_active && (hipri_req_i || cmd_valid_i)) |=> (scan_active && $stable(scan_idx))); // R6

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (scan_active && !hipri_req_i && !cmd_valid_i && scan_idx != LAST_IDX) |=>
      (scan_active && scan_idx == $past(scan_idx) + 1'b1)); // R3

  AST_SCAN_ENDS: assert property (@(posedge clk) disable iff (rst)
    (scan_active && !hipri_req_i && !cmd_valid_i && scan_idx == LAST_IDX) |=> !scan_active); // R3

  AST_DISABLED_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (!run_en_i && !busy_o && !reg_wr_i) |=> (!busy_o && $stable(tick_cnt_o))); // R9
endmodule

bind tmr_table_scan tmr_table_scan_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .run_en_i    (run_en_i),
  .hipri_req_i (hipri_req_i),
  .cmd_valid_i (cmd_valid_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .event_o     (event_o),
  .mask_o      (mask_o),
  .tick_cnt_o  (tick_cnt_o),
  .irq_o       (irq_o),
  .busy_o      (busy_o),
  .scan_active (scan_active),
  .scan_idx    (scan_idx)
);

// File: tb/tmr_table_scan_tb_top.sv
module tmr_table_scan_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en_i = 1'b0, tick_i = 1'b0, hipri_req_i = 1'b0;
  logic        cmd_valid_i = 1'b0, reg_wr_i = 1'b0;
  logic [31:0] cmd_word_i = '0, reg_wdata_i = '0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] event_o, mask_o, tick_cnt_o;
  logic        irq_o, busy_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  tmr_table_scan dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [31:0] w);
    @(negedge clk); cmd_valid_i = 1'b1; cmd_word_i = w;
    @(negedge clk); cmd_valid_i = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk); reg_wr_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy_o; i++) @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
      wait_idle();
    end
  endtask

  task automatic t_reset();
    chk("R1 event", event_o, 0);
    chk("R1 mask", mask_o, 0);
    chk("R1 tickcnt", tick_cnt_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 busy", busy_o, 0);
    tick_n(1);
    chk("R1 no entry valid", event_o, 0);
  endtask

  task automatic t_example_word();
    reg_write(2'd2, 0);
    do_cmd(32'hC000_080D);
    repeat (20) @(negedge clk);
    chk("R2 no count before tick", busy_o, 0);
    tick_n(2060);
    chk("R2 entry0 before 2061", event_o[0], 0);
    tick_n(1);
    chk("R2 entry0 at 2061", event_o[0], 1);
    chk("R7 tickcnt 2061", tick_cnt_o, 2061);
    do_cmd(32'h0000_0000);
    reg_write(2'd0, 32'hFFFF);
    chk("R4 clear all", event_o, 0);
  endtask

  task automatic t_oneshot();
    do_cmd(32'h8003_0003);
    tick_n(2);
    chk("R3 count3 after 2", event_o, 0);
    tick_n(1);
    chk("R3 count3 after 3", event_o, 16'h0008);
    reg_write(2'd0, 32'h0008);
    tick_n(3);
    chk("R5 retired stays silent", event_o, 0);
    do_cmd(32'h8009_0000);
    tick_n(1);
    chk("R3 count0 acts as 1", event_o, 16'h0200);
    reg_write(2'd0, 32'hFFFF);
  endtask

  task automatic t_restart();
    do_cmd(32'hC007_0005);
    tick_n(5);
    chk("R5 first period", event_o, 16'h0080);
    reg_write(2'd0, 32'h0080);
    tick_n(4);
    chk("R5 before reload period", event_o, 0);
    tick_n(1);
    chk("R5 second period", event_o, 16'h0080);
    do_cmd(32'h0007_0000);
    reg_write(2'd0, 32'hFFFF);
    tick_n(6);
    chk("R2 disable command retires", event_o, 0);
  endtask

  task automatic t_w1c_mask();
    do_cmd(32'h8001_0001);
    do_cmd(32'h8002_0001);
    tick_n(1);
    chk("R4 two events", event_o, 16'h0006);
    chk("R8 masked off irq", irq_o, 0);
    reg_write(2'd0, 32'h0002);
    chk("R4 selective clear", event_o, 16'h0004);
    reg_write(2'd1, 32'h0004);
    chk("R8 mask reg", mask_o, 16'h0004);
    @(negedge clk);
    chk("R8 irq on", irq_o, 1);
    reg_write(2'd1, 32'h0001);
    @(negedge clk);
    chk("R8 irq off other mask", irq_o, 0);
    reg_write(2'd0, 32'hFFFF);
  endtask

  task automatic t_stall();
    logic [15:0] tc;
    tc = tick_cnt_o;
    do_cmd(32'h8000_0005);
    @(negedge clk); hipri_req_i = 1'b1;
    tick_n(0);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    repeat (40) @(negedge clk);
    chk("R6 held busy", busy_o, 1);
    chk("R6 held no count", tick_cnt_o, tc);
    do_cmd(32'h8000_0001);
    @(negedge clk); hipri_req_i = 1'b0;
    wait_idle();
    chk("R6 resumed count", tick_cnt_o, tc + 16'd1);
    chk("R6 command wins", event_o, 16'h0001);
    reg_write(2'd0, 32'hFFFF);
  endtask

  task automatic t_disabled_queue();
    logic [15:0] tc;
    tc = tick_cnt_o;
    @(negedge clk); run_en_i = 1'b0; tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    chk("R9 no scan", busy_o, 0);
    repeat (20) @(negedge clk);
    chk("R9 tickcnt held", tick_cnt_o, tc);
    @(negedge clk); run_en_i = 1'b1; tick_i = 1'b1;
    @(negedge clk);
    @(negedge clk); tick_i = 1'b0;
    wait_idle();
    chk("R10 queued ticks", tick_cnt_o, tc + 16'd2);
    reg_write(2'd2, 32'h0055);
    chk("R7 write loads", tick_cnt_o, 16'h0055);
    tick_n(1);
    chk("R7 increments", tick_cnt_o, 16'h0056);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_en_i = 1'b1;
    t_example_word();
    t_oneshot();
    t_restart();
    t_w1c_mask();
    t_stall();
    t_disabled_queue();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule